// File: doc/BRIEF.md
# Thread-Tagged Direct-Mapped Branch Target Buffer

This block holds predicted branch targets for a fetch unit that several hardware threads share. The storage is a plain register array with one entry per index and no associativity. The fetch stage presents a program counter and the ID of the requesting thread. In the same cycle, with no register on the path, the block answers with a hit flag and the stored target. When the entry does not belong to that PC and thread, the target reads as zero.

When a branch resolves, the update port writes an entry. The entry is chosen from the PC and thread alone and is overwritten without any check of its old contents. The owning thread ID is stored next to the tag, so one thread never uses another thread's prediction. A build-time option folds the thread ID into the upper index bits. With it on, threads running the same code land in different entries instead of evicting each other.

The entry count and the thread count must both be powers of two. The design refuses to elaborate otherwise.

Top module: `thread_btb`

## Requirements
- R1: After the synchronous active-low reset is released, every lookup misses: hit is 0 and the target is 0.
- R2: After an update of (PC, thread, target), a lookup with the same PC and thread in any later cycle hits and returns that target, as long as no other write reaches that entry.
- R3: Whenever hit is 0, the target output is exactly zero.
- R4: A lookup that reaches an entry whose stored tag matches, but whose stored thread ID differs from the requesting one, misses.
- R5: The tag is PC bits [SHIFT+IDX_W+TAG_W-1 : SHIFT+IDX_W], which lie directly above the index bits. A PC that differs only in these bits selects the same entry, misses against it, and replaces it when written.
- R6: The PC offset bits [SHIFT-1:0] take no part in indexing or matching. A lookup whose PC differs from the written PC only in these bits hits.
- R7: With hashing enabled, the entry index is PC[SHIFT+IDX_W-1:SHIFT] XOR (thread << (IDX_W - log2(THREADS))). The same PC from two threads therefore keeps two separate entries. With the default build, a thread-1 PC equal to a thread-0 PC XOR 0x10 reaches the thread-0 entry.
- R8: An update always overwrites its entry, replacing the valid bit, tag, thread and target, even when the entry already holds a valid match.
- R9: If a lookup and an update reach the same entry in the same cycle, the lookup returns the contents from before the write. The new contents are seen from the next cycle on.
- R10: PC bits above the tag field do not affect the result. A lookup whose PC differs only in such a bit hits.
- R11: A reset applied after entries have been written invalidates all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears every valid bit |
| lk_pc | input | PC_W | Program counter presented for lookup |
| lk_tid | input | TID_W | Thread issuing the lookup |
| lk_hit | output | 1 | Combinational: the selected entry belongs to this PC and thread |
| lk_target | output | PC_W | Combinational: stored target on a hit, zero otherwise |
| up_en | input | 1 | Write the entry selected by up_pc and up_tid at the next edge |
| up_pc | input | PC_W | Program counter of the resolved branch |
| up_tid | input | TID_W | Thread that resolved the branch |
| up_target | input | PC_W | Target to store |

## Verification
The hardest case to reach from the ports is the owner check alone: the tag matches but the thread differs. With hashing on, the same PC from two threads never reaches the same entry. The bench therefore builds a second PC whose index bits are the first PC's index bits XOR the two threads' hash terms, keeping the tag bits the same. The lookup from the other thread then lands on the written entry with an equal tag, so only the thread comparison can make it miss. A same-cycle write and lookup on one entry, followed by a reset in the middle of the run, cover the read-before-write timing and the invalidation.

// File: rtl/btb_pkg.sv
// Package: shared helpers for the thread-tagged branch target buffer.
// Assumes: called only with elaboration-time constants.
package btb_pkg;

    // True when v is a positive power of two.
    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Width that holds a thread ID; never less than one bit.
    function automatic int tid_width(input int threads);
        return (threads > 1) ? $clog2(threads) : 1;
    endfunction

endpackage

// File: rtl/btb_index_hash.sv
// Module: btb_index_hash
// Splits a PC into the entry index and the tag. When HASH_EN is set and
// there is more than one thread, it folds the thread ID into the top
// TH_BITS bits of the index.
// Assumes: PC_W >= SHIFT + IDX_W + TAG_W and TH_BITS <= IDX_W.
module btb_index_hash #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 8,
    parameter int TID_W   = 2,
    parameter int TH_BITS = 2,
    parameter int SHIFT   = 2,
    parameter bit HASH_EN = 1'b1
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TID_W-1:0] tid,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam int TAG_LSB = SHIFT + IDX_W;

    logic [IDX_W-1:0] raw_idx;
    logic             unused_bits;

    // Index bits sit just above the instruction offset.
    assign raw_idx = pc[SHIFT +: IDX_W];
    // Tag bits sit just above the index bits.
    assign tag     = pc[TAG_LSB +: TAG_W];
    // Offset bits and high PC bits are intentionally ignored.
    assign unused_bits = ^{pc, tid};

    generate
        if (HASH_EN && (TH_BITS > 0)) begin : g_hash
            localparam int TSH = IDX_W - TH_BITS;
            // Spread threads by XORing their ID into the top index bits.
            assign idx = raw_idx ^ (IDX_W'(tid) << TSH);
        end else begin : g_plain
            // No thread spreading: the index comes from the PC alone.
            assign idx = raw_idx;
        end
    endgenerate
endmodule

// File: rtl/btb_store.sv
// Module: btb_store
// Register array of ENTRIES entries holding valid, tag, owner thread and
// target. One write port and one combinational read port. A read during a
// write to the same entry returns the old contents.
// Assumes: synchronous active-low reset clears the valid bits only.
module btb_store #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 8,
    parameter int TID_W   = 2,
    parameter int TGT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [TAG_W-1:0] wtag,
    input  logic [TID_W-1:0] wtid,
    input  logic [TGT_W-1:0] wtgt,
    input  logic [IDX_W-1:0] ridx,
    output logic             rvalid,
    output logic [TAG_W-1:0] rtag,
    output logic [TID_W-1:0] rtid,
    output logic [TGT_W-1:0] rtgt
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TID_W-1:0]   tid_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    // Valid bits: cleared by reset, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[widx] <= 1'b1;
        end
    end

    // Payload fields: overwritten on every write, with no reset needed.
    always_ff @(posedge clk) begin
        if (rst_n && we) begin
            tag_q[widx] <= wtag;
            tid_q[widx] <= wtid;
            tgt_q[widx] <= wtgt;
        end
    end

    // Combinational read of the selected entry.
    assign rvalid = valid_q[ridx];
    assign rtag   = tag_q[ridx];
    assign rtid   = tid_q[ridx];
    assign rtgt   = tgt_q[ridx];

    AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) |-> valid_q[$past(widx)]);  // R8

    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));  // R11
endmodule

// File: rtl/btb_match.sv
// Module: btb_match
// Decides hit from the entry's valid bit, tag and owner thread. Forces the
// target to zero on a miss.
// Assumes: purely combinational, fed by btb_store and btb_index_hash.
module btb_match #(
    parameter int TAG_W = 8,
    parameter int TID_W = 2,
    parameter int TGT_W = 32
) (
    input  logic             e_valid,
    input  logic [TAG_W-1:0] e_tag,
    input  logic [TID_W-1:0] e_tid,
    input  logic [TGT_W-1:0] e_tgt,
    input  logic [TAG_W-1:0] q_tag,
    input  logic [TID_W-1:0] q_tid,
    output logic             hit,
    output logic [TGT_W-1:0] target
);
    // A hit needs valid, equal tag and the same owner thread.
    always_comb begin
        hit    = e_valid && (e_tag == q_tag) && (e_tid == q_tid);
        target = hit ? e_tgt : '0;
    end
endmodule

// File: rtl/thread_btb.sv
// Module: thread_btb (top)
// Direct-mapped branch target buffer shared by THREADS hardware threads.
// Lookup is combinational. An update writes at the next rising edge.
// Assumes: ENTRIES and THREADS are powers of two,
// log2(THREADS) <= log2(ENTRIES), and PC_W >= SHIFT + log2(ENTRIES) + TAG_W.
module thread_btb #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 8,
    parameter int SHIFT   = 2,
    parameter int THREADS = 4,
    parameter bit HASH_EN = 1'b1,
    localparam int TID_W  = btb_pkg::tid_width(THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    input  logic [TID_W-1:0] lk_tid,
    output logic             lk_hit,
    output logic [PC_W-1:0]  lk_target,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [TID_W-1:0] up_tid,
    input  logic [PC_W-1:0]  up_target
);
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int TH_BITS = $clog2(THREADS);

    // Elaboration-time parameter checks.
    generate
        if (!btb_pkg::is_pow2(ENTRIES)) begin : g_bad_entries
            $error("thread_btb: ENTRIES must be a power of two");
        end
        if (!btb_pkg::is_pow2(THREADS)) begin : g_bad_threads
            $error("thread_btb: THREADS must be a power of two");
        end
        if (TH_BITS > IDX_W) begin : g_bad_hash
            $error("thread_btb: too many threads for the index width");
        end
        if (PC_W < SHIFT + IDX_W + TAG_W) begin : g_bad_pc
            $error("thread_btb: PC too narrow for offset, index and tag");
        end
    endgenerate

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             e_valid;
    logic [TAG_W-1:0] e_tag;
    logic [TID_W-1:0] e_tid;
    logic [PC_W-1:0]  e_tgt;

    btb_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W),
                     .TH_BITS(TH_BITS), .SHIFT(SHIFT), .HASH_EN(HASH_EN))
    u_lk_hash (.pc(lk_pc), .tid(lk_tid), .idx(lk_idx), .tag(lk_tag));

    btb_index_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W),
                     .TH_BITS(TH_BITS), .SHIFT(SHIFT), .HASH_EN(HASH_EN))
    u_up_hash (.pc(up_pc), .tid(up_tid), .idx(up_idx), .tag(up_tag));

    btb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .TID_W(TID_W), .TGT_W(PC_W))
    u_store (.clk(clk), .rst_n(rst_n), .we(up_en), .widx(up_idx),
             .wtag(up_tag), .wtid(up_tid), .wtgt(up_target),
             .ridx(lk_idx), .rvalid(e_valid), .rtag(e_tag), .rtid(e_tid),
             .rtgt(e_tgt));

    btb_match #(.TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(PC_W))
    u_match (.e_valid(e_valid), .e_tag(e_tag), .e_tid(e_tid), .e_tgt(e_tgt),
             .q_tag(lk_tag), .q_tid(lk_tid), .hit(lk_hit), .target(lk_target));

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == '0));  // R3

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);  // R1

    AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(up_en) && (lk_pc == $past(up_pc)) &&
        (lk_tid == $past(up_tid))
        |-> lk_hit && (lk_target == $past(up_target)));  // R2
endmodule

// File: tb/sim_thread_btb.sv
// Directed bench for thread_btb with default parameters:
// SHIFT=2, 16 entries (4 index bits), 8 tag bits, 4 threads, hashing on.
module sim_thread_btb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_tid = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        up_en = 1'b0;
    logic [31:0] up_pc = '0;
    logic [1:0]  up_tid = '0;
    logic [31:0] up_target = '0;

    int checks = 0;
    int failures = 0;

    localparam logic [31:0] P1 = 32'h0000_1A48;
    localparam logic [31:0] T1 = 32'h0000_8000;
    localparam logic [31:0] T2 = 32'h0000_9004;
    localparam logic [31:0] T3 = 32'h0000_A008;
    localparam logic [31:0] T4 = 32'h0000_B00C;
    localparam logic [31:0] T5 = 32'h0000_C010;
    localparam logic [31:0] T6 = 32'h0000_D014;

    always #2.5 clk = ~clk;

    thread_btb u0 (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_tid(lk_tid),
                   .lk_hit(lk_hit), .lk_target(lk_target), .up_en(up_en),
                   .up_pc(up_pc), .up_tid(up_tid), .up_target(up_target));

    task automatic expect_lk(input string req, input logic [31:0] pc,
                             input logic [1:0] tid, input logic hit,
                             input logic [31:0] tgt);
        lk_pc = pc;
        lk_tid = tid;
        #1;
        checks++;
        if (lk_hit !== hit || lk_target !== tgt) begin
            failures++;
            $display("FAIL %s pc=%h tid=%0d: hit=%b target=%h, expected hit=%b target=%h",
                     req, pc, tid, lk_hit, lk_target, hit, tgt);
        end
    endtask

    task automatic write_entry(input logic [31:0] pc, input logic [1:0] tid,
                               input logic [31:0] tgt);
        @(negedge clk);
        up_pc = pc; up_tid = tid; up_target = tgt; up_en = 1'b1;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        expect_lk("R1", P1, 2'd0, 1'b0, 32'h0);
        expect_lk("R1", 32'h0000_0000, 2'd3, 1'b0, 32'h0);
        expect_lk("R3", 32'hFFFF_FFFC, 2'd2, 1'b0, 32'h0);
    endtask

    task automatic t_basic();
        write_entry(P1, 2'd0, T1);
        expect_lk("R2", P1, 2'd0, 1'b1, T1);
        expect_lk("R6", P1 | 32'h3, 2'd0, 1'b1, T1);
        expect_lk("R10", P1 | 32'h0010_0000, 2'd0, 1'b1, T1);
        expect_lk("R5", P1 ^ 32'h40, 2'd0, 1'b0, 32'h0);
    endtask

    task automatic t_threads();
        write_entry(P1, 2'd1, T2);
        expect_lk("R7", P1, 2'd0, 1'b1, T1);
        expect_lk("R7", P1, 2'd1, 1'b1, T2);
    endtask

    task automatic t_owner_alias();
        // Thread 1 PC with index bits XOR (0^1)<<2 reaches the thread-0 entry.
        logic [31:0] pa;
        pa = P1 ^ 32'h10;
        expect_lk("R4", pa, 2'd1, 1'b0, 32'h0);
        write_entry(pa, 2'd1, T3);
        expect_lk("R8", pa, 2'd1, 1'b1, T3);
        expect_lk("R7", P1, 2'd0, 1'b0, 32'h0);
        expect_lk("R7", P1, 2'd1, 1'b1, T2);
    endtask

    task automatic t_overwrite();
        write_entry(P1, 2'd1, T4);
        expect_lk("R8", P1, 2'd1, 1'b1, T4);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        up_pc = P1; up_tid = 2'd1; up_target = T5; up_en = 1'b1;
        expect_lk("R9", P1, 2'd1, 1'b1, T4);
        @(negedge clk);
        up_en = 1'b0;
        expect_lk("R9", P1, 2'd1, 1'b1, T5);
    endtask

    task automatic t_tag_replace();
        write_entry(P1 ^ 32'h40, 2'd1, T6);
        expect_lk("R5", P1 ^ 32'h40, 2'd1, 1'b1, T6);
        expect_lk("R5", P1, 2'd1, 1'b0, 32'h0);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_lk("R11", P1 ^ 32'h40, 2'd1, 1'b0, 32'h0);
        expect_lk("R11", P1 ^ 32'h10, 2'd1, 1'b0, 32'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic();
        t_threads();
        t_owner_alias();
        t_overwrite();
        t_same_cycle();
        t_tag_replace();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule